// File: doc/BRIEF.md
# Free-Running 64-bit Timer with Compare and Periodic Reload

This block holds a 64-bit up-counter driven through an 8-bit clock divider, one 64-bit compare value, an event flag and a level interrupt. Software reaches it through a plain 32-bit register port that decodes a 256-byte window. Each 64-bit quantity appears as two 32-bit words, low word at the lower offset.

A compare hit happens when the counter steps onto the compare value. The hit sets the event flag. When reload is enabled, the same hit also advances the compare value by a programmed 32-bit step. The timer then produces evenly spaced events forever without software rearming it. The interrupt line stays high while the flag and the interrupt enable are both set.

Top module: `ctmr_timer`

## Requirements
- R1: After a synchronous reset every register reads zero and `irq` is low.
- R2: Word offsets are: counter low 0x00, counter high 0x04, control 0x08, status 0x0C, compare low 0x10, compare high 0x14, reload step 0x18. An address that is unaligned or unused reads zero and ignores writes. The control word reads back only bits 0..3 and 15:8; other bits read zero.
- R3: While control bit 0 (run) is set, the counter increases by one every P+1 clock cycles, where P is control bits 15:8. While run is clear the counter holds.
- R4: Every write to the control word restarts the divider from zero and produces no count step in that cycle. The first step after such a write therefore comes P+1 cycles later.
- R5: Writes to either counter word are ignored while run is set. They load the word while run is clear.
- R6: When control bit 1 (compare enable) is set, the event flag (status bit 0) is set on the clock edge where the counter steps onto the compare value. Loading the counter with the compare value, holding equality while stopped, or passing the value with compare enable clear does not set it.
- R7: When control bit 3 (reload) is set, a compare hit adds the zero-extended 32-bit step to the 64-bit compare value on the same edge that sets the flag. A software write to a compare word in that cycle takes priority for that word.
- R8: Writing status with bit 0 = 1 clears the flag, and writing bit 0 = 0 has no effect. If a hit and a clear fall on the same edge, the flag stays set.
- R9: `irq` is high exactly while the event flag and control bit 2 (interrupt enable) are both set.
- R10: The counter is a true 64-bit value: a step from low word 0xFFFFFFFF carries into the high word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the divider input |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address within the 256-byte window |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A divider phase error shows up on the very next count step as an early or late counter value, so the bench reads the counter on the exact cycle before and after each expected step. A compare value that is wrong after a reload stays hidden until the following period, when the flag rises on the wrong cycle. For that reason the reload run checks both the reloaded compare words and the flag at the next expected hit. A stale or mis-prioritised flag is visible at once on status and `irq`, and it is probed on the cycle of a coinciding hit and clear.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int WORD_W  = 32;
    localparam int CNT_W   = 2 * WORD_W;
    localparam int PRE_W   = 8;
    localparam int ADDR_W  = 8;
    localparam int IDX_W   = ADDR_W - 2;

    localparam logic [IDX_W-1:0] IDX_CNT_LO = 6'h00;
    localparam logic [IDX_W-1:0] IDX_CNT_HI = 6'h01;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 6'h02;
    localparam logic [IDX_W-1:0] IDX_STAT   = 6'h03;
    localparam logic [IDX_W-1:0] IDX_CMP_LO = 6'h04;
    localparam logic [IDX_W-1:0] IDX_CMP_HI = 6'h05;
    localparam logic [IDX_W-1:0] IDX_STEP   = 6'h06;

    localparam int PRE_LSB = 8;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic             reload;
        logic             irq_en;
        logic             cmp_en;
        logic             run;
    } ctrl_t;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic ctrl;
        logic stat;
        logic cmp_lo;
        logic cmp_hi;
        logic step;
    } wr_strobe_t;

    function automatic ctrl_t word_to_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.presc  = w[PRE_LSB +: PRE_W];
        c.reload = w[3];
        c.irq_en = w[2];
        c.cmp_en = w[1];
        c.run    = w[0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[PRE_LSB +: PRE_W] = c.presc;
        w[3] = c.reload;
        w[2] = c.irq_en;
        w[1] = c.cmp_en;
        w[0] = c.run;
        return w;
    endfunction

endpackage

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler
    import ctmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);

    logic [PRE_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (run) begin
            if (phase_q == presc) phase_q <= '0;
            else                  phase_q <= phase_q + PRE_W'(1);
        end
    end

    assign tick = run && !restart && (phase_q == presc);

    // divider phase never passes the programmed limit
    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
        phase_q <= presc);

    // a restart always lands the phase at zero
    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_q == '0));

endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter
    import ctmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);

    localparam int NWORDS = CNT_W / WORD_W;

    logic [CNT_W-1:0] cnt_q;
    logic [NWORDS-1:0] wsel;

    assign wsel = {wr_hi, wr_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            for (int w = 0; w < NWORDS; w++) begin
                if (wsel[w]) cnt_q[w*WORD_W +: WORD_W] <= wdata;
            end
        end
    end

    assign cnt = cnt_q;

    // each divider tick is one count step, carrying across words
    assert_step_R10: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // no tick and no load: value is frozen
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_lo && !wr_hi) |=> $stable(cnt_q));

endmodule

// File: rtl/ctmr_comparator.sv
module ctmr_comparator
    import ctmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              tick,
    input  logic              cmp_en,
    input  logic              reload,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_step,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp,
    output logic [WORD_W-1:0] step,
    output logic              hit
);

    localparam int NWORDS = CNT_W / WORD_W;

    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  cmp_adv;
    logic [WORD_W-1:0] step_q;
    logic [NWORDS-1:0] wsel;

    assign wsel    = {wr_hi, wr_lo};
    assign hit     = cmp_en && tick && ((cnt + CNT_W'(1)) == cmp_q);
    assign cmp_adv = cmp_q + {{(CNT_W-WORD_W){1'b0}}, step_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else begin
            for (int w = 0; w < NWORDS; w++) begin
                if (wsel[w])
                    cmp_q[w*WORD_W +: WORD_W] <= wdata;
                else if (hit && reload)
                    cmp_q[w*WORD_W +: WORD_W] <= cmp_adv[w*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          step_q <= '0;
        else if (wr_step) step_q <= wdata;
    end

    assign cmp  = cmp_q;
    assign step = step_q;

    // reload advances by the step on a hit
    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && reload && !wr_lo && !wr_hi) |=>
            (cmp_q == $past(cmp_q) + {{(CNT_W-WORD_W){1'b0}}, $past(step_q)}));

    // without reload and without writes the compare value is fixed
    assert_cmp_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        (!reload && !wr_lo && !wr_hi) |=> $stable(cmp_q));

endmodule

// File: rtl/ctmr_status.sv
module ctmr_status (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    input  logic irq_en,
    output logic evt,
    output logic irq
);

    logic evt_q;

    always_ff @(posedge clk) begin
        if (rst)      evt_q <= 1'b0;
        else if (hit) evt_q <= 1'b1;
        else if (clr) evt_q <= 1'b0;
    end

    assign evt = evt_q;
    assign irq = evt_q && irq_en;

    // a hit always leaves the flag set, even against a clear
    assert_hit_sets_R8: assert property (@(posedge clk) disable iff (rst)
        hit |=> evt_q);

    // a lone clear drops the flag
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !evt_q);

    // flag only rises from a hit
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_q) |-> $past(hit));

endmodule

// File: rtl/ctmr_timer.sv
module ctmr_timer
    import ctmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);

    ctrl_t             ctrl_q;
    wr_strobe_t        wr;
    logic [IDX_W-1:0]  idx;
    logic              aligned;
    logic              tick;
    logic              hit;
    logic              evt;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic [WORD_W-1:0] step;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    always_comb begin
        wr = '0;
        if (bus_we && aligned) begin
            case (idx)
                IDX_CNT_LO: wr.cnt_lo = !ctrl_q.run;
                IDX_CNT_HI: wr.cnt_hi = !ctrl_q.run;
                IDX_CTRL:   wr.ctrl   = 1'b1;
                IDX_STAT:   wr.stat   = 1'b1;
                IDX_CMP_LO: wr.cmp_lo = 1'b1;
                IDX_CMP_HI: wr.cmp_hi = 1'b1;
                IDX_STEP:   wr.step   = 1'b1;
                default:    wr        = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr.ctrl) ctrl_q <= word_to_ctrl(bus_wdata);
    end

    ctmr_prescaler u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .restart (wr.ctrl),
        .presc   (ctrl_q.presc),
        .tick    (tick)
    );

    ctmr_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .wr_lo (wr.cnt_lo),
        .wr_hi (wr.cnt_hi),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    ctmr_comparator u_cmp (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .tick    (tick),
        .cmp_en  (ctrl_q.cmp_en),
        .reload  (ctrl_q.reload),
        .wr_lo   (wr.cmp_lo),
        .wr_hi   (wr.cmp_hi),
        .wr_step (wr.step),
        .wdata   (bus_wdata),
        .cmp     (cmp),
        .step    (step),
        .hit     (hit)
    );

    ctmr_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .clr    (wr.stat && bus_wdata[0]),
        .irq_en (ctrl_q.irq_en),
        .evt    (evt),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                IDX_CNT_LO: bus_rdata = cnt[WORD_W-1:0];
                IDX_CNT_HI: bus_rdata = cnt[CNT_W-1:WORD_W];
                IDX_CTRL:   bus_rdata = ctrl_to_word(ctrl_q);
                IDX_STAT:   bus_rdata = {{(WORD_W-1){1'b0}}, evt};
                IDX_CMP_LO: bus_rdata = cmp[WORD_W-1:0];
                IDX_CMP_HI: bus_rdata = cmp[CNT_W-1:WORD_W];
                IDX_STEP:   bus_rdata = step;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // counter word writes while running leave only the count step
    assert_cnt_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && bus_we && aligned && (idx == IDX_CNT_LO) && !tick)
            |=> $stable(cnt));

    // a hit needs compare enable at that edge
    assert_hit_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.cmp_en && !evt) |=> !evt);

endmodule

// File: tb/sim_ctmr_timer.sv
module sim_ctmr_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctmr_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_rd(input string req, input logic [7:0] a,
                             input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, $sformatf("read 0x%02h", a), {32'h0, d}, {32'h0, exp});
    endtask

    task automatic t_reset;
        for (int a = 0; a < 7; a++) expect_rd("R1", 8'(a * 4), 32'h0);
        chk("R1", "irq", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_regmap;
        wr(8'h18, 32'hA5A5_0001);
        expect_rd("R2", 8'h18, 32'hA5A5_0001);
        wr(8'h10, 32'h1111_2222);
        wr(8'h14, 32'h3333_4444);
        expect_rd("R2", 8'h10, 32'h1111_2222);
        expect_rd("R2", 8'h14, 32'h3333_4444);
        wr(8'h08, 32'hFFFF_FFF0);
        expect_rd("R2", 8'h08, 32'h0000_FF00);
        wr(8'h1C, 32'hFFFF_FFFF);
        expect_rd("R2", 8'h1C, 32'h0);
        expect_rd("R2", 8'hFC, 32'h0);
        wr(8'h19, 32'h0);
        expect_rd("R2", 8'h19, 32'h0);
        expect_rd("R2", 8'h18, 32'hA5A5_0001);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h0000_0301);
        wait_n(3);
        expect_rd("R3", 8'h00, 32'd0);
        wait_n(1);
        expect_rd("R3", 8'h00, 32'd1);
        wait_n(4);
        expect_rd("R3", 8'h00, 32'd2);
        wait_n(2);
        wr(8'h08, 32'h0000_0301);
        wait_n(3);
        expect_rd("R4", 8'h00, 32'd2);
        wait_n(1);
        expect_rd("R4", 8'h00, 32'd3);
        wr(8'h08, 32'h0);
        rd(8'h00, v);
        wait_n(6);
        expect_rd("R3", 8'h00, v);
    endtask

    task automatic t_carry;
        wr(8'h00, 32'hFFFF_FFFE);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h1);
        wait_n(2);
        expect_rd("R10", 8'h00, 32'h0);
        expect_rd("R10", 8'h04, 32'h1);
        wr(8'h00, 32'h1234);
        expect_rd("R5", 8'h00, 32'h1);
        expect_rd("R5", 8'h04, 32'h1);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h1234);
        wr(8'h04, 32'h0);
        expect_rd("R5", 8'h00, 32'h1234);
        expect_rd("R5", 8'h04, 32'h0);
    endtask

    task automatic t_match;
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h10, 32'd5);
        wr(8'h14, 32'h0);
        wr(8'h08, 32'h7);
        wait_n(4);
        expect_rd("R6", 8'h00, 32'd4);
        expect_rd("R6", 8'h0C, 32'h0);
        chk("R9", "irq before hit", {63'h0, irq}, 64'h0);
        wait_n(1);
        expect_rd("R6", 8'h00, 32'd5);
        expect_rd("R6", 8'h0C, 32'h1);
        chk("R9", "irq at hit", {63'h0, irq}, 64'h1);
        wr(8'h0C, 32'h0);
        expect_rd("R8", 8'h0C, 32'h1);
        wr(8'h08, 32'h6);
        wr(8'h08, 32'h2);
        chk("R9", "irq masked", {63'h0, irq}, 64'h0);
        expect_rd("R9", 8'h0C, 32'h1);
        wr(8'h08, 32'h6);
        chk("R9", "irq unmasked", {63'h0, irq}, 64'h1);
        wr(8'h0C, 32'h1);
        expect_rd("R8", 8'h0C, 32'h0);
        chk("R9", "irq after clear", {63'h0, irq}, 64'h0);
        wr(8'h00, 32'd5);
        wait_n(3);
        expect_rd("R6", 8'h0C, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h5);
        wait_n(6);
        expect_rd("R6", 8'h00, 32'd6);
        expect_rd("R6", 8'h0C, 32'h0);
        wr(8'h08, 32'h0);
    endtask

    task automatic t_reload;
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h10, 32'd3);
        wr(8'h14, 32'h0);
        wr(8'h18, 32'd4);
        wr(8'h08, 32'hB);
        wait_n(3);
        expect_rd("R7", 8'h00, 32'd3);
        expect_rd("R7", 8'h0C, 32'h1);
        expect_rd("R7", 8'h10, 32'd7);
        wr(8'h0C, 32'h1);
        expect_rd("R8", 8'h0C, 32'h0);
        wait_n(2);
        expect_rd("R7", 8'h0C, 32'h0);
        wait_n(1);
        expect_rd("R7", 8'h0C, 32'h1);
        expect_rd("R7", 8'h10, 32'd11);
        expect_rd("R7", 8'h14, 32'h0);
        wait_n(3);
        wr(8'h0C, 32'h1);
        expect_rd("R8", 8'h0C, 32'h1);
        expect_rd("R7", 8'h10, 32'd15);
        wr(8'h08, 32'h0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_prescale();
        t_carry();
        t_match();
        t_reload();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule